// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

This block lets several processors exchange 32-bit words through a small register window. Six independent queues, each four words deep, carry the messages. A sender writes a word to a queue's message register. A receiver reads the same register to take the oldest word out. Every queue also has a read-only full flag and a read-only word count, so software can poll a queue without changing it.

Four interrupt users can watch the queues. Each user has its own status register and its own enable register. Each of these registers has two bits per queue: one for "a word is waiting" and one for "there is room". Both status bits behave as level-backed sticky bits. A bit is set whenever its condition holds. A write of one clears it, but the clear only stays while the condition is false. The interrupt line of a user is high whenever any enabled status bit of that user is set.

A revision word, a system status word and a two-bit idle configuration register complete the register window. The idle bits are only stored and read back. They have no effect inside the block.

Top module: `ipc_mailbox`

## Requirements
- R1: Reset empties every queue and clears all status, enable and configuration bits, and holds every interrupt line low. Offset 0x000 always reads the constant 0x0000_0102, and writes to it are ignored. Offset 0x014 reads 1.
- R2: A write to the message register of queue n (offset 0x040 + 4·n) appends the write data to that queue. A read of that register returns and removes the oldest word, so words leave a queue in the order they entered it.
- R3: A queue holds at most 4 words, and a write to a full queue is dropped. The full register of queue n (offset 0x080 + 4·n) reads 1 when the queue holds 4 words and 0 otherwise.
- R4: A read of the message register of an empty queue returns 0 and leaves the count and every status bit unchanged.
- R5: The count register of queue n (offset 0x0C0 + 4·n) reads the number of words the queue holds, from 0 to 4.
- R6: User u has a status register at offset 0x100 + 8·u and an enable register at 0x104 + 8·u, for u = 0 to 3. The enable register is readable and writable. The interrupt line irq_out[u] is high exactly when the status and enable registers of user u share a set bit.
- R7: In the status and enable registers, bit 2·n belongs to the new-message event of queue n and bit 2·n+1 to its not-full event. The not-full bit of every user is set at the end of any cycle in which its queue is not full. A write of 1 clears it only while the queue is full.
- R8: The new-message bit of every user is set at the end of any cycle in which its queue holds at least one word. A write of 1 to that bit clears it only when the queue is empty. Once set, the bit stays set after the queue empties, until it is cleared.
- R9: The configuration register (offset 0x010) stores bits 0 and 4 from a write. All its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; message reads pop the queue |
| bus_addr | input | 9 | Byte address of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read strobe |
| irq_out | output | 4 | One interrupt line per user |

## Verification
A wrong queue pointer or count shows up at the ports on the next read. The popped word, the count or the full flag then disagrees with the order and number of words written. The test drives each queue to full and back to empty to expose such faults. A status bit that loses its level backing shows up in the first status read after a clear. The bit stays at 0 although the queue condition still holds, and the test reads status right after clearing a bit in both the full and the non-full state. A wrong enable or status mask shows up on irq_out in the cycle right after the write that should change it.

// File: rtl/ipc_mailbox_pkg.sv
// Package: register offsets and the register-kind enumeration shared by
// the mailbox top, its sub-units and its checker.
// Assumes word-aligned byte addressing on the register bus.
package ipc_mailbox_pkg;

    localparam int OFS_REV    = 'h000;
    localparam int OFS_CFG    = 'h010;
    localparam int OFS_SYS    = 'h014;
    localparam int OFS_MSG    = 'h040;
    localparam int OFS_FULL   = 'h080;
    localparam int OFS_CNT    = 'h0C0;
    localparam int OFS_IRQ    = 'h100;
    localparam int IRQ_STRIDE = 8;
    localparam int Q_STRIDE   = 4;

    localparam int CFG_AUTO_BIT  = 0;
    localparam int CFG_SMART_BIT = 4;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_REV,
        RK_CFG,
        RK_SYS,
        RK_MSG,
        RK_FULL,
        RK_CNT,
        RK_IRQST,
        RK_IRQEN
    } reg_kind_e;

endpackage

// File: rtl/ipc_mbx_fifo.sv
// Module: one message queue of the mailbox.
// A circular buffer with separate read and write pointers and a word count.
// A push into a full queue and a pop from an empty queue are ignored.
// Assumes at most one push and one pop per cycle.
module ipc_mbx_fifo #(
    parameter  int DATA_W = 32,
    parameter  int DEPTH  = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o,
    output logic              empty_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count_q;
    logic              push_ok;
    logic              pop_ok;

    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign empty_o = (count_q == '0);
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign head_o  = mem[rd_ptr];
    assign count_o = count_q;

    // Purpose: store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata_i;
        end
    end

    // Purpose: advance the pointers and keep the word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

endmodule

// File: rtl/ipc_mbx_irq_unit.sv
// Module: status and enable registers and the interrupt line of one user.
// Each status bit is set from the next-cycle queue condition and cleared by
// a write of one. A clear takes effect only when the condition is false.
// Assumes the condition inputs already reflect this cycle's push or pop.
module ipc_mbx_irq_unit #(
    parameter  int NQ    = 6,
    localparam int IRQ_W = 2 * NQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] wbits_i,
    input  logic [NQ-1:0]    nonempty_nx_i,
    input  logic [NQ-1:0]    notfull_nx_i,
    output logic [IRQ_W-1:0] status_o,
    output logic [IRQ_W-1:0] enable_o,
    output logic             irq_o
);

    logic [IRQ_W-1:0] set_bits;
    logic [IRQ_W-1:0] clr_bits;

    // Interleave the two event kinds: even bit = new message, odd = room.
    for (genvar n = 0; n < NQ; n++) begin : g_map
        assign set_bits[2*n]     = nonempty_nx_i[n];
        assign set_bits[2*n + 1] = notfull_nx_i[n];
    end

    assign clr_bits = clr_we ? wbits_i : '0;
    assign irq_o    = |(status_o & enable_o);

    // Purpose: sticky status with level re-set, and the writable enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            enable_o <= '0;
        end else begin
            status_o <= (status_o & ~clr_bits) | set_bits;
            if (en_we) begin
                enable_o <= wbits_i;
            end
        end
    end

endmodule

// File: rtl/ipc_mailbox.sv
// Module: multi-queue interprocessor mailbox, top level.
// Decodes the register window, owns the configuration bits and the read data
// register, and instantiates one queue per channel and one interrupt unit
// per user. Assumes bus_wr and bus_rd are not both high in one cycle.
module ipc_mailbox
    import ipc_mailbox_pkg::*;
#(
    parameter int          NQ       = 6,
    parameter int          NU       = 4,
    parameter int          DEPTH    = 4,
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 9,
    parameter logic [31:0] REVISION = 32'h0000_0102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NU-1:0]     irq_out
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IRQ_W = 2 * NQ;

    logic [31:0]       a_ext;
    reg_kind_e         sel_kind;
    int                sel_idx;

    logic [DATA_W-1:0] q_head  [NQ];
    logic [CNT_W-1:0]  q_count [NQ];
    logic [NQ-1:0]     q_full;
    logic [NQ-1:0]     q_empty;
    logic [NQ-1:0]     q_push;
    logic [NQ-1:0]     q_pop;
    logic [NQ-1:0]     nonempty_nx;
    logic [NQ-1:0]     notfull_nx;

    logic [IRQ_W-1:0]  st_q [NU];
    logic [IRQ_W-1:0]  en_q [NU];

    logic              cfg_auto;
    logic              cfg_smart;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign a_ext = 32'(bus_addr);

    // Purpose: map the bus address to a register kind and a queue/user index.
    always_comb begin
        sel_kind = RK_NONE;
        sel_idx  = 0;
        if (a_ext[1:0] == 2'b00) begin
            if (a_ext == OFS_REV) begin
                sel_kind = RK_REV;
            end else if (a_ext == OFS_CFG) begin
                sel_kind = RK_CFG;
            end else if (a_ext == OFS_SYS) begin
                sel_kind = RK_SYS;
            end else if (a_ext >= OFS_MSG && a_ext < OFS_MSG + Q_STRIDE * NQ) begin
                sel_kind = RK_MSG;
                sel_idx  = int'((a_ext - OFS_MSG) / Q_STRIDE);
            end else if (a_ext >= OFS_FULL && a_ext < OFS_FULL + Q_STRIDE * NQ) begin
                sel_kind = RK_FULL;
                sel_idx  = int'((a_ext - OFS_FULL) / Q_STRIDE);
            end else if (a_ext >= OFS_CNT && a_ext < OFS_CNT + Q_STRIDE * NQ) begin
                sel_kind = RK_CNT;
                sel_idx  = int'((a_ext - OFS_CNT) / Q_STRIDE);
            end else if (a_ext >= OFS_IRQ && a_ext < OFS_IRQ + IRQ_STRIDE * NU) begin
                sel_kind = a_ext[2] ? RK_IRQEN : RK_IRQST;
                sel_idx  = int'((a_ext - OFS_IRQ) / IRQ_STRIDE);
            end
        end
    end

    // One queue per channel, with its next-cycle conditions for the status bits.
    for (genvar n = 0; n < NQ; n++) begin : g_queue
        logic [CNT_W-1:0] cnt_nx;

        assign q_push[n] = bus_wr && (sel_kind == RK_MSG) && (sel_idx == n);
        assign q_pop[n]  = bus_rd && (sel_kind == RK_MSG) && (sel_idx == n);

        assign cnt_nx = q_count[n]
                      + CNT_W'(q_push[n] && !q_full[n])
                      - CNT_W'(q_pop[n] && !q_empty[n]);
        assign nonempty_nx[n] = (cnt_nx != '0);
        assign notfull_nx[n]  = (cnt_nx != CNT_W'(DEPTH));

        ipc_mbx_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) fifo_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (q_push[n]),
            .pop_i   (q_pop[n]),
            .wdata_i (bus_wdata),
            .head_o  (q_head[n]),
            .count_o (q_count[n]),
            .full_o  (q_full[n]),
            .empty_o (q_empty[n])
        );
    end

    // One interrupt unit per user.
    for (genvar u = 0; u < NU; u++) begin : g_user
        logic en_we;
        logic clr_we;

        assign en_we  = bus_wr && (sel_kind == RK_IRQEN) && (sel_idx == u);
        assign clr_we = bus_wr && (sel_kind == RK_IRQST) && (sel_idx == u);

        ipc_mbx_irq_unit #(
            .NQ (NQ)
        ) irq_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .en_we         (en_we),
            .clr_we        (clr_we),
            .wbits_i       (bus_wdata[IRQ_W-1:0]),
            .nonempty_nx_i (nonempty_nx),
            .notfull_nx_i  (notfull_nx),
            .status_o      (st_q[u]),
            .enable_o      (en_q[u]),
            .irq_o         (irq_out[u])
        );
    end

    // Purpose: store the two idle-mode configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_auto  <= 1'b0;
            cfg_smart <= 1'b0;
        end else if (bus_wr && sel_kind == RK_CFG) begin
            cfg_auto  <= bus_wdata[CFG_AUTO_BIT];
            cfg_smart <= bus_wdata[CFG_SMART_BIT];
        end
    end

    // Purpose: select the read value for the addressed register.
    always_comb begin
        rd_mux = '0;
        unique case (sel_kind)
            RK_REV:  rd_mux = DATA_W'(REVISION);
            RK_CFG:  rd_mux = (DATA_W'(cfg_smart) << CFG_SMART_BIT)
                            | (DATA_W'(cfg_auto) << CFG_AUTO_BIT);
            RK_SYS:  rd_mux = DATA_W'(1);
            RK_MSG: begin
                for (int n = 0; n < NQ; n++) begin
                    if (sel_idx == n && !q_empty[n]) rd_mux = q_head[n];
                end
            end
            RK_FULL: begin
                for (int n = 0; n < NQ; n++) begin
                    if (sel_idx == n) rd_mux = DATA_W'(q_full[n]);
                end
            end
            RK_CNT: begin
                for (int n = 0; n < NQ; n++) begin
                    if (sel_idx == n) rd_mux = DATA_W'(q_count[n]);
                end
            end
            RK_IRQST: begin
                for (int u = 0; u < NU; u++) begin
                    if (sel_idx == u) rd_mux = DATA_W'(st_q[u]);
                end
            end
            RK_IRQEN: begin
                for (int u = 0; u < NU; u++) begin
                    if (sel_idx == u) rd_mux = DATA_W'(en_q[u]);
                end
            end
            default: rd_mux = '0;
        endcase
    end

    // Purpose: register the read data; it is valid one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= bus_rd ? rd_mux : '0;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/ipc_mailbox_chk.sv
// Module: assertion checker for the mailbox, bound into every instance.
// Watches the bus ports, the queue counts and the per-user status registers.
module ipc_mailbox_chk
    import ipc_mailbox_pkg::*;
#(
    parameter  int NQ     = 6,
    parameter  int NU     = 4,
    parameter  int DEPTH  = 4,
    parameter  int DATA_W = 32,
    parameter  int ADDR_W = 9,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IRQ_W  = 2 * NQ
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NU-1:0]     irq_out,
    input logic [CNT_W-1:0]  q_count [NQ],
    input logic [IRQ_W-1:0]  st_q    [NU]
);

    logic armed;

    // Purpose: mark the cycles after the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    for (genvar n = 0; n < NQ; n++) begin : g_q
        assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(OFS_MSG + Q_STRIDE * n) && q_count[n] == CNT_W'(DEPTH))
            |=> (q_count[n] == CNT_W'(DEPTH)));

        assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == ADDR_W'(OFS_MSG + Q_STRIDE * n) && q_count[n] == '0)
            |=> (bus_rdata == '0 && q_count[n] == '0));

        for (genvar u = 0; u < NU; u++) begin : g_u
            assert_notfull_level_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                (q_count[n] != CNT_W'(DEPTH)) |-> st_q[u][2*n + 1]);

            assert_newmsg_level_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                (q_count[n] != '0) |-> st_q[u][2*n]);
        end
    end

    for (genvar u = 0; u < NU; u++) begin : g_irq
        assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(OFS_IRQ + IRQ_STRIDE * u + 4) && bus_wdata == '0)
            |=> !irq_out[u]);
    end

    assert_cfg_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_CFG))
        |=> ((bus_rdata & ~DATA_W'(32'h11)) == '0));

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .NQ     (NQ),
    .NU     (NU),
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .q_count   (q_count),
    .st_q      (st_q)
);

// File: tb/ipc_mailbox_tb_top.sv
// Bench: walks a table of bus operations with expected results, then runs
// directed reset checks. Reports through its own check and error counters.
module ipc_mailbox_tb_top;

    localparam int OP_WR  = 0;
    localparam int OP_RD  = 1;
    localparam int OP_IRQ = 2;
    localparam int NVEC   = 54;
    localparam int WDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ipc_mailbox dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Layout: {op[1:0], addr[8:0], wdata[31:0], expected[31:0], req[3:0]}
    localparam logic [78:0] VEC [NVEC] = '{
        {2'd1, 9'h000, 32'h0, 32'h0000_0102, 4'd1},  // R1 revision
        {2'd1, 9'h010, 32'h0, 32'h0000_0000, 4'd1},  // R1 config cleared
        {2'd1, 9'h014, 32'h0, 32'h0000_0001, 4'd1},  // R1 system status
        {2'd1, 9'h100, 32'h0, 32'h0000_0AAA, 4'd7},  // R7 all not-full bits
        {2'd1, 9'h118, 32'h0, 32'h0000_0AAA, 4'd7},  // R7 user 3
        {2'd1, 9'h0C0, 32'h0, 32'h0000_0000, 4'd5},  // R5 empty count
        {2'd0, 9'h040, 32'h1111_1111, 32'h0, 4'd2},
        {2'd0, 9'h040, 32'h2222_2222, 32'h0, 4'd2},
        {2'd1, 9'h0C0, 32'h0, 32'h0000_0002, 4'd5},  // R5
        {2'd1, 9'h080, 32'h0, 32'h0000_0000, 4'd3},  // R3 not full
        {2'd1, 9'h100, 32'h0, 32'h0000_0AAB, 4'd7},  // R7 new message q0
        {2'd1, 9'h108, 32'h0, 32'h0000_0AAB, 4'd7},  // R7 user 1
        {2'd1, 9'h040, 32'h0, 32'h1111_1111, 4'd2},  // R2 oldest first
        {2'd1, 9'h040, 32'h0, 32'h2222_2222, 4'd2},  // R2
        {2'd1, 9'h040, 32'h0, 32'h0000_0000, 4'd4},  // R4 empty read
        {2'd1, 9'h0C0, 32'h0, 32'h0000_0000, 4'd4},  // R4 count unchanged
        {2'd0, 9'h100, 32'h0000_0001, 32'h0, 4'd8},
        {2'd1, 9'h100, 32'h0, 32'h0000_0AAA, 4'd8},  // R8 clear sticks when empty
        {2'd1, 9'h108, 32'h0, 32'h0000_0AAB, 4'd8},  // R8 other user untouched
        {2'd0, 9'h054, 32'hA000_0000, 32'h0, 4'd3},
        {2'd0, 9'h054, 32'hA000_0001, 32'h0, 4'd3},
        {2'd0, 9'h054, 32'hA000_0002, 32'h0, 4'd3},
        {2'd0, 9'h054, 32'hA000_0003, 32'h0, 4'd3},
        {2'd0, 9'h054, 32'hA000_0004, 32'h0, 4'd3},
        {2'd1, 9'h094, 32'h0, 32'h0000_0001, 4'd3},  // R3 full flag
        {2'd1, 9'h0D4, 32'h0, 32'h0000_0004, 4'd5},  // R5 capped at 4
        {2'd1, 9'h100, 32'h0, 32'h0000_0EAA, 4'd8},  // R8 q5 new message
        {2'd0, 9'h100, 32'h0000_0800, 32'h0, 4'd7},
        {2'd1, 9'h100, 32'h0, 32'h0000_06AA, 4'd7},  // R7 clear sticks when full
        {2'd0, 9'h100, 32'h0000_0400, 32'h0, 4'd8},
        {2'd1, 9'h100, 32'h0, 32'h0000_06AA, 4'd8},  // R8 re-set while non-empty
        {2'd1, 9'h054, 32'h0, 32'hA000_0000, 4'd2},  // R2
        {2'd1, 9'h100, 32'h0, 32'h0000_0EAA, 4'd7},  // R7 room again
        {2'd1, 9'h094, 32'h0, 32'h0000_0000, 4'd3},  // R3
        {2'd1, 9'h054, 32'h0, 32'hA000_0001, 4'd2},
        {2'd1, 9'h054, 32'h0, 32'hA000_0002, 4'd2},
        {2'd1, 9'h054, 32'h0, 32'hA000_0003, 4'd2},
        {2'd1, 9'h054, 32'h0, 32'h0000_0000, 4'd3},  // R3 fifth word dropped
        {2'd0, 9'h010, 32'hFFFF_FFFF, 32'h0, 4'd9},
        {2'd1, 9'h010, 32'h0, 32'h0000_0011, 4'd9},  // R9 only bits 0 and 4
        {2'd0, 9'h000, 32'h1234_5678, 32'h0, 4'd1},
        {2'd1, 9'h000, 32'h0, 32'h0000_0102, 4'd1},  // R1 revision read-only
        {2'd0, 9'h104, 32'h0000_0001, 32'h0, 4'd6},
        {2'd2, 9'h000, 32'h0, 32'h0000_0000, 4'd6},  // R6 enabled bit not set
        {2'd0, 9'h040, 32'hCAFE_0001, 32'h0, 4'd6},
        {2'd2, 9'h000, 32'h0, 32'h0000_0001, 4'd6},  // R6 user 0 fires
        {2'd0, 9'h10C, 32'h0000_0002, 32'h0, 4'd6},
        {2'd2, 9'h000, 32'h0, 32'h0000_0003, 4'd6},  // R6 user 1 not-full
        {2'd1, 9'h104, 32'h0, 32'h0000_0001, 4'd6},  // R6 enable readback
        {2'd0, 9'h104, 32'h0000_0000, 32'h0, 4'd6},
        {2'd2, 9'h000, 32'h0, 32'h0000_0002, 4'd6},  // R6 masked
        {2'd0, 9'h108, 32'h0000_0002, 32'h0, 4'd7},
        {2'd2, 9'h000, 32'h0, 32'h0000_0002, 4'd7},  // R7 not-full re-sets
        {2'd1, 9'h040, 32'h0, 32'hCAFE_0001, 4'd2}   // R2
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_addr = a;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        for (int c = 0; c < WDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic [78:0] v;
        repeat (3) @(negedge clk);
        check(1, 32'(irq_out), 32'h0);       // R1 lines low during reset
        check(1, bus_rdata, 32'h0);          // R1 read data cleared
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            case (int'(v[78:77]))
                OP_WR:  bus_write(v[76:68], v[67:36]);
                OP_RD: begin
                    bus_read(v[76:68], rd);
                    check(int'(v[3:0]), rd, v[35:4]);
                end
                OP_IRQ: begin
                    @(negedge clk);
                    check(int'(v[3:0]), 32'(irq_out), v[35:4]);
                end
                default: ;
            endcase
        end

        // Directed: reset in the middle of traffic clears everything (R1).
        bus_write(9'h048, 32'h5555_0000);
        bus_write(9'h114, 32'h0000_0FFF);
        @(negedge clk);
        check(6, 32'(irq_out[2]), 32'h1);    // R6 user 2 fires
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(1, 32'(irq_out), 32'h0);       // R1
        rst_n = 1'b1;
        bus_read(9'h0C8, rd);
        check(1, rd, 32'h0);                 // R1 queue 2 emptied
        bus_read(9'h114, rd);
        check(1, rd, 32'h0);                 // R1 enable cleared
        bus_read(9'h010, rd);
        check(1, rd, 32'h0);                 // R1 config cleared
        bus_read(9'h048, rd);
        check(4, rd, 32'h0);                 // R4 empty after reset

        done = 1'b1;
        finish_run();
    end

endmodule